// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit settles the outcome of one jump-class instruction per cycle. It takes the 8-bit opcode, the value of the first operand register, the value of the second operand register, the 32-bit immediate, the signed 16-bit displacement, the index in the instruction's source-register field and the current program counter. The program counter counts 64-bit instruction slots. The unit reports whether control moves to the branch target and which slot executes next. It also raises a flag when the instruction is a call, an exit or an illegal encoding.

Two compare classes are handled. Class 5 compares the full 64-bit operands. Class 6 compares only the low 32 bits. The unconditional jump, the call and the exit are accepted only in class 5. Every result is registered, so a request sampled on one rising edge appears on the outputs right after that edge and stays there until the next accepted request.

Top module: `br_resolve_unit`

## Requirements
- R1: While reset is low, out_valid, out_taken, out_call, out_exit, out_illegal and out_next_pc are all zero. A request accepted with in_valid high at a rising edge drives out_valid high after that edge, and out_valid is low after an edge where in_valid was low.
- R2: Class 5 (opcode bits [2:0] = 5) compares all 64 bits. Class 6 (bits [2:0] = 6) compares only bits [31:0] of both operands and ignores the upper 32 bits.
- R3: Opcode bit 3 = 1 selects in_src_val as the second operand. Bit 3 = 0 selects in_imm, which is sign-extended from bit 31 to 64 bits in class 5.
- R4: Unsigned conditions, taken when true, with the code in opcode bits [7:4]: 0x2 first > second, 0x3 first >= second, 0xA first < second, 0xB first <= second.
- R5: Signed conditions, using two's complement at the compare width: 0x6 greater, 0x7 greater-or-equal, 0xC less, 0xD less-or-equal.
- R6: Code 0x1 is taken on equality, code 0x5 on inequality, and code 0x4 when the bitwise AND of the operands is nonzero.
- R7: When taken, out_next_pc = in_pc + 1 + sign-extended in_offset, modulo 2^PC_W. When not taken, out_next_pc = in_pc + 1.
- R8: In class 5, code 0x0 is always taken. In class 5, code 0x9 sets out_exit and is not taken.
- R9: In class 5, code 0x8 sets out_call. With in_src_idx = 1 (local call) it is taken to the relative target. With in_src_idx = 0 or 2 (helper call) it is not taken. Any other in_src_idx makes the instruction illegal.
- R10: out_illegal is set, with out_taken, out_call and out_exit all low and out_next_pc = in_pc + 1, in these cases: the class is neither 5 nor 6; the code is 0xE or 0xF; or the code is 0x0, 0x8 or 0x9 in class 6.
- R11: At most one of out_call, out_exit and out_illegal is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_opcode | input | 8 | Instruction opcode |
| in_src_idx | input | 4 | Source-register field of the instruction |
| in_dst_val | input | DATA_W (64) | First operand register value |
| in_src_val | input | DATA_W (64) | Second operand register value |
| in_imm | input | IMM_W (32) | Immediate field |
| in_offset | input | OFF_W (16) | Signed slot displacement |
| in_pc | input | PC_W (32) | Current program counter in slots |
| out_valid | output | 1 | Result present |
| out_taken | output | 1 | Control moves to the target |
| out_next_pc | output | PC_W (32) | Slot to execute next |
| out_call | output | 1 | Instruction is a call |
| out_exit | output | 1 | Instruction is an exit |
| out_illegal | output | 1 | Encoding not accepted |

## Verification
The bench places operands so that the upper 32 bits disagree while the low halves agree. A design that ignores the compare width then picks the wrong direction in one of the two classes. It uses negative immediates and operands near the sign boundary. These expose a missing sign extension, or signed and unsigned codes that have been swapped, because the order then flips. It drives jump, call and exit in class 6, out-of-range call kinds, codes 0xE and 0xF, and non-jump classes, where a design that forgets an illegal case would take the branch or raise a call or exit flag. It also uses displacements that wrap the program counter past zero. These catch a target that omits the +1 or zero-extends the displacement.

// File: rtl/br_pkg.sv
// Package: shared encodings and the decoded-instruction record for the
// branch resolution unit. Assumes the opcode layout code[7:4], sel[3], class[2:0].
package br_pkg;

    localparam logic [2:0] CLS_WIDE   = 3'd5;
    localparam logic [2:0] CLS_NARROW = 3'd6;

    typedef enum logic [3:0] {
        C_ALWAYS = 4'h0, C_EQ   = 4'h1, C_UGT  = 4'h2, C_UGE  = 4'h3,
        C_ANY    = 4'h4, C_NE   = 4'h5, C_SGT  = 4'h6, C_SGE  = 4'h7,
        C_CALL   = 4'h8, C_EXIT = 4'h9, C_ULT  = 4'hA, C_ULE  = 4'hB,
        C_SLT    = 4'hC, C_SLE  = 4'hD, C_BADE = 4'hE, C_BADF = 4'hF
    } cond_code_e;

    typedef struct packed {
        logic wide;      // full-width compare class
        logic is_cond;   // outcome depends on the compare
        logic always_go; // unconditional transfer (jump or local call)
        logic call;
        logic quit;      // exit
        logic illegal;
    } dec_t;

endpackage

// File: rtl/br_decode.sv
// Module: br_decode
// Classifies an opcode into conditional, unconditional, call, exit or
// illegal. Assumes the caller has already split out the source-register field.
module br_decode
    import br_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic [3:0] src_idx,
    output dec_t       dec
);

    logic [2:0] cls;
    logic [3:0] code;
    logic       wide;
    logic       jmp_cls;

    assign cls     = opcode[2:0];
    assign code    = opcode[7:4];
    assign wide    = (cls == CLS_WIDE);
    assign jmp_cls = wide || (cls == CLS_NARROW);

    // Purpose: map class and code onto the decoded record.
    always_comb begin
        dec         = '0;
        dec.wide    = wide;
        if (!jmp_cls) begin
            dec.illegal = 1'b1;
        end else begin
            unique case (cond_code_e'(code))
                C_EQ, C_UGT, C_UGE, C_ANY, C_NE, C_SGT, C_SGE,
                C_ULT, C_ULE, C_SLT, C_SLE: dec.is_cond = 1'b1;
                C_ALWAYS: begin
                    dec.always_go = wide;
                    dec.illegal   = !wide;
                end
                C_CALL: begin
                    if (wide && (src_idx <= 4'd2)) begin
                        dec.call      = 1'b1;
                        dec.always_go = (src_idx == 4'd1);
                    end else begin
                        dec.illegal = 1'b1;
                    end
                end
                C_EXIT: begin
                    dec.quit    = wide;
                    dec.illegal = !wide;
                end
                default: dec.illegal = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/br_operand_sel.sv
// Module: br_operand_sel
// Picks the second operand and normalises both operands to DATA_W bits.
// In the narrow class each operand is sign-extended from its low half, which
// preserves equality, bit-test, signed and unsigned order at half width, so
// the comparator needs no width input. Assumes IMM_W equals DATA_W/2.
module br_operand_sel #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32
) (
    input  logic              wide,
    input  logic              use_reg,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] op_a,
    output logic [DATA_W-1:0] op_b
);

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] b_raw;

    assign imm_ext = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
    assign b_raw   = use_reg ? src_val : imm_ext;

    // Purpose: pass full-width operands or fold them to the low half.
    always_comb begin
        if (wide) begin
            op_a = dst_val;
            op_b = b_raw;
        end else begin
            op_a = {{HALF_W{dst_val[HALF_W-1]}}, dst_val[HALF_W-1:0]};
            op_b = {{HALF_W{b_raw[HALF_W-1]}},   b_raw[HALF_W-1:0]};
        end
    end

endmodule

// File: rtl/br_cond_eval.sv
// Module: br_cond_eval
// Evaluates one of the eleven compare conditions on two DATA_W operands.
// Assumes operands were already normalised for the compare width.
module br_cond_eval
    import br_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [3:0]        code,
    output logic              cond_true
);

    logic eq, ltu, lts, any;

    assign eq  = (op_a == op_b);
    assign ltu = (op_a < op_b);
    assign lts = ($signed(op_a) < $signed(op_b));
    assign any = |(op_a & op_b);

    // Purpose: select the relation named by the condition code.
    always_comb begin
        unique case (cond_code_e'(code))
            C_EQ:    cond_true = eq;
            C_NE:    cond_true = !eq;
            C_ANY:   cond_true = any;
            C_UGT:   cond_true = !ltu && !eq;
            C_UGE:   cond_true = !ltu;
            C_ULT:   cond_true = ltu;
            C_ULE:   cond_true = ltu || eq;
            C_SGT:   cond_true = !lts && !eq;
            C_SGE:   cond_true = !lts;
            C_SLT:   cond_true = lts;
            C_SLE:   cond_true = lts || eq;
            default: cond_true = 1'b0;
        endcase
    end

endmodule

// File: rtl/br_target.sv
// Module: br_target
// Forms the next program counter in instruction slots: the fall-through slot,
// plus the sign-extended displacement when taken. Wraps modulo 2^PC_W.
// Assumes PC_W > OFF_W.
module br_target #(
    parameter int PC_W  = 32,
    parameter int OFF_W = 16
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    input  logic             taken,
    output logic [PC_W-1:0]  next_pc
);

    logic [PC_W-1:0] fall_thru;
    logic [PC_W-1:0] disp;

    assign fall_thru = pc + PC_W'(1);
    assign disp      = {{(PC_W-OFF_W){offset[OFF_W-1]}}, offset};

    // Purpose: choose the fall-through slot or the displaced one.
    always_comb begin
        next_pc = taken ? (fall_thru + disp) : fall_thru;
    end

endmodule

// File: rtl/br_resolve_unit.sv
// Module: br_resolve_unit (top)
// Resolves one jump-class instruction per accepted request and registers
// the outcome. One cycle latency, no back-pressure. Assumes IMM_W = DATA_W/2.
module br_resolve_unit
    import br_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32,
    parameter int OFF_W  = 16,
    parameter int PC_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_opcode,
    input  logic [3:0]        in_src_idx,
    input  logic [DATA_W-1:0] in_dst_val,
    input  logic [DATA_W-1:0] in_src_val,
    input  logic [IMM_W-1:0]  in_imm,
    input  logic [OFF_W-1:0]  in_offset,
    input  logic [PC_W-1:0]   in_pc,
    output logic              out_valid,
    output logic              out_taken,
    output logic [PC_W-1:0]   out_next_pc,
    output logic              out_call,
    output logic              out_exit,
    output logic              out_illegal
);

    dec_t              dec;
    logic [DATA_W-1:0] op_a, op_b;
    logic              cond_true;
    logic              taken;
    logic [PC_W-1:0]   next_pc;

    br_decode u_dec (
        .opcode  (in_opcode),
        .src_idx (in_src_idx),
        .dec     (dec)
    );

    br_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ops (
        .wide    (dec.wide),
        .use_reg (in_opcode[3]),
        .dst_val (in_dst_val),
        .src_val (in_src_val),
        .imm     (in_imm),
        .op_a    (op_a),
        .op_b    (op_b)
    );

    br_cond_eval #(.DATA_W(DATA_W)) u_cmp (
        .op_a      (op_a),
        .op_b      (op_b),
        .code      (in_opcode[7:4]),
        .cond_true (cond_true)
    );

    assign taken = !dec.illegal && (dec.always_go || (dec.is_cond && cond_true));

    br_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
        .pc      (in_pc),
        .offset  (in_offset),
        .taken   (taken),
        .next_pc (next_pc)
    );

    // Purpose: register the resolved outcome of each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_taken   <= 1'b0;
            out_next_pc <= '0;
            out_call    <= 1'b0;
            out_exit    <= 1'b0;
            out_illegal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_taken   <= taken;
                out_next_pc <= next_pc;
                out_call    <= dec.call;
                out_exit    <= dec.quit;
                out_illegal <= dec.illegal;
            end
        end
    end

    // R1: a result only follows an accepted request
    assert_valid_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R7: not taken means the fall-through slot
    assert_fallthru_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_taken) |-> (out_next_pc == $past(in_pc) + PC_W'(1)));

    // R8: wide unconditional jump with immediate select is always taken
    assert_uncond_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_opcode) == 8'h05) |-> out_taken);

    // R8: exit never transfers control
    assert_exit_not_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_exit) |-> !out_taken);

    // R10: a non-jump class is flagged illegal and does nothing
    assert_bad_class_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_opcode[2:0]) != 3'd5 && $past(in_opcode[2:0]) != 3'd6)
        |-> (out_illegal && !out_taken));

    // R11: flags are mutually exclusive
    assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_call, out_exit, out_illegal}));

endmodule

// File: tb/tb_br_resolve_unit.sv
`timescale 1ns/1ps
module tb_br_resolve_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [7:0]  in_opcode;
    logic [3:0]  in_src_idx;
    logic [63:0] in_dst_val, in_src_val;
    logic [31:0] in_imm;
    logic [15:0] in_offset;
    logic [31:0] in_pc;
    logic        out_valid, out_taken, out_call, out_exit, out_illegal;
    logic [31:0] out_next_pc;

    always #2.5 clk = ~clk;

    br_resolve_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opcode(in_opcode),
        .in_src_idx(in_src_idx), .in_dst_val(in_dst_val), .in_src_val(in_src_val),
        .in_imm(in_imm), .in_offset(in_offset), .in_pc(in_pc),
        .out_valid(out_valid), .out_taken(out_taken), .out_next_pc(out_next_pc),
        .out_call(out_call), .out_exit(out_exit), .out_illegal(out_illegal)
    );

    typedef struct packed {
        logic        taken;
        logic        call;
        logic        quit;
        logic        bad;
        logic [31:0] npc;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;

    // Reference outcome computed from the requirement text.
    function automatic exp_t model(input logic [7:0] opc, input logic [3:0] sidx,
                                   input logic [63:0] d, input logic [63:0] s,
                                   input logic [31:0] im, input logic [15:0] off,
                                   input logic [31:0] pc);
        exp_t  e;
        logic  wide, narrow, c, go;
        logic [63:0] b64;
        logic [31:0] a32, b32;
        logic [3:0]  code;
        e      = '0;
        code   = opc[7:4];
        wide   = (opc[2:0] == 3'd5);
        narrow = (opc[2:0] == 3'd6);
        b64    = opc[3] ? s : {{32{im[31]}}, im};
        a32    = d[31:0];
        b32    = opc[3] ? s[31:0] : im;
        c      = 1'b0;
        go     = 1'b0;
        if (wide) begin
            case (code)
                4'h1: c = (d == b64);
                4'h5: c = (d != b64);
                4'h4: c = ((d & b64) != 64'd0);
                4'h2: c = (d > b64);
                4'h3: c = (d >= b64);
                4'hA: c = (d < b64);
                4'hB: c = (d <= b64);
                4'h6: c = ($signed(d) > $signed(b64));
                4'h7: c = ($signed(d) >= $signed(b64));
                4'hC: c = ($signed(d) < $signed(b64));
                4'hD: c = ($signed(d) <= $signed(b64));
                default: c = 1'b0;
            endcase
        end else begin
            case (code)
                4'h1: c = (a32 == b32);
                4'h5: c = (a32 != b32);
                4'h4: c = ((a32 & b32) != 32'd0);
                4'h2: c = (a32 > b32);
                4'h3: c = (a32 >= b32);
                4'hA: c = (a32 < b32);
                4'hB: c = (a32 <= b32);
                4'h6: c = ($signed(a32) > $signed(b32));
                4'h7: c = ($signed(a32) >= $signed(b32));
                4'hC: c = ($signed(a32) < $signed(b32));
                4'hD: c = ($signed(a32) <= $signed(b32));
                default: c = 1'b0;
            endcase
        end
        if (!wide && !narrow)                    e.bad = 1'b1;
        else if (code == 4'hE || code == 4'hF)   e.bad = 1'b1;
        else if (code == 4'h0)                   begin e.bad = narrow; go = wide; end
        else if (code == 4'h9)                   begin e.bad = narrow; e.quit = wide; end
        else if (code == 4'h8) begin
            if (narrow || sidx > 4'd2) e.bad = 1'b1;
            else begin e.call = 1'b1; go = (sidx == 4'd1); end
        end else go = c;
        e.taken = go && !e.bad;
        e.npc   = pc + 32'd1 + (e.taken ? {{16{off[15]}}, off} : 32'd0);
        return e;
    endfunction

    // Driver: present one request and queue its expected result.
    task automatic send(input string tag, input logic [7:0] opc, input logic [3:0] sidx,
                        input logic [63:0] d, input logic [63:0] s, input logic [31:0] im,
                        input logic [15:0] off, input logic [31:0] pc);
        @(negedge clk);
        in_valid   = 1'b1;
        in_opcode  = opc;
        in_src_idx = sidx;
        in_dst_val = d;
        in_src_val = s;
        in_imm     = im;
        in_offset  = off;
        in_pc      = pc;
        exp_q.push_back(model(opc, sidx, d, s, im, off, pc));
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: compare each produced result against the queue head.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            exp_t  e;
            string t;
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R1: unexpected result, got valid=1 expected valid=0");
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({out_taken, out_call, out_exit, out_illegal, out_next_pc} !== e) begin
                    bad++;
                    $display("FAIL %s: got taken=%0b call=%0b exit=%0b illegal=%0b npc=%h expected taken=%0b call=%0b exit=%0b illegal=%0b npc=%h",
                             t, out_taken, out_call, out_exit, out_illegal, out_next_pc,
                             e.taken, e.call, e.quit, e.bad, e.npc);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got running expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_opcode = '0; in_src_idx = '0;
        in_dst_val = '0; in_src_val = '0; in_imm = '0; in_offset = '0; in_pc = '0;
        repeat (3) @(negedge clk);
        total++;
        if ({out_valid, out_taken, out_call, out_exit, out_illegal, out_next_pc} !== '0) begin
            bad++;
            $display("FAIL R1: reset outputs got %b expected 0",
                     {out_valid, out_taken, out_call, out_exit, out_illegal});
        end
        rst_n = 1'b1;

        // R2: upper halves differ, low halves equal
        send("R2", 8'h1D, 0, 64'h1_0000_0005, 64'h2_0000_0005, 0, 16'd10, 32'd100);
        send("R2", 8'h1E, 0, 64'h1_0000_0005, 64'h2_0000_0005, 0, 16'd10, 32'd100);
        send("R2", 8'h2E, 0, 64'h0_0000_0001, 64'h7_0000_0002, 0, 16'd4, 32'd7);
        // R3: immediate select and sign extension
        send("R3", 8'h15, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 32'hFFFF_FFFF, 16'd3, 32'd20);
        send("R3", 8'h15, 0, 64'h0000_0000_FFFF_FFFF, 0, 32'hFFFF_FFFF, 16'd3, 32'd20);
        send("R3", 8'h16, 0, 64'h0000_0000_FFFF_FFFF, 0, 32'hFFFF_FFFF, 16'd3, 32'd20);
        send("R3", 8'h1D, 0, 64'd9, 64'd9, 32'd1, 16'd2, 32'd30);
        // R4: unsigned order with top bit set
        send("R4", 8'h2D, 0, 64'h8000_0000_0000_0000, 64'd1, 0, 16'd5, 32'd40);
        send("R4", 8'hAD, 0, 64'h8000_0000_0000_0000, 64'd1, 0, 16'd5, 32'd40);
        send("R4", 8'h3D, 0, 64'd7, 64'd7, 0, 16'd5, 32'd40);
        send("R4", 8'hBE, 0, 64'd8, 64'd7, 0, 16'd5, 32'd40);
        // R5: signed order across the sign boundary
        send("R5", 8'h6D, 0, 64'h8000_0000_0000_0000, 64'd1, 0, 16'd6, 32'd50);
        send("R5", 8'hCD, 0, 64'h8000_0000_0000_0000, 64'd1, 0, 16'd6, 32'd50);
        send("R5", 8'h7E, 0, 64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, 0, 16'd6, 32'd50);
        send("R5", 8'hDE, 0, 64'd3, 64'd3, 0, 16'd6, 32'd50);
        send("R5", 8'hC5, 0, 64'hFFFF_FFFF_FFFF_FFFE, 0, 32'hFFFF_FFFF, 16'd6, 32'd50);
        // R6: equal, not equal, bit test
        send("R6", 8'h5D, 0, 64'd1, 64'd2, 0, 16'd8, 32'd60);
        send("R6", 8'h4D, 0, 64'h1_0000_0000, 64'h1_0000_0000, 0, 16'd8, 32'd60);
        send("R6", 8'h4E, 0, 64'h1_0000_0000, 64'h1_0000_0000, 0, 16'd8, 32'd60);
        // R7: wrap-around targets
        send("R7", 8'h05, 0, 0, 0, 0, 16'hFFFF, 32'd0);
        send("R7", 8'h05, 0, 0, 0, 0, 16'hFFF6, 32'd5);
        send("R7", 8'h05, 0, 0, 0, 0, 16'h7FFF, 32'hFFFF_FFF0);
        // R8: exit
        send("R8", 8'h95, 0, 0, 0, 0, 16'd9, 32'd70);
        // R9: call kinds
        send("R9", 8'h85, 0, 0, 0, 0, 16'd12, 32'd80);
        send("R9", 8'h85, 1, 0, 0, 0, 16'd12, 32'd80);
        send("R9", 8'h85, 2, 0, 0, 0, 16'd12, 32'd80);
        send("R9", 8'h85, 3, 0, 0, 0, 16'd12, 32'd80);
        // R10: illegal encodings
        send("R10", 8'h06, 0, 0, 0, 0, 16'd4, 32'd90);
        send("R10", 8'h86, 1, 0, 0, 0, 16'd4, 32'd90);
        send("R10", 8'h96, 0, 0, 0, 0, 16'd4, 32'd90);
        send("R10", 8'hED, 0, 64'd1, 64'd1, 0, 16'd4, 32'd90);
        send("R10", 8'hF5, 0, 0, 0, 0, 16'd4, 32'd90);
        send("R10", 8'h1F, 0, 64'd1, 64'd1, 0, 16'd4, 32'd90);
        send("R10", 8'h04, 0, 0, 0, 0, 16'd4, 32'd90);
        idle();
        // R1: no result after an idle cycle
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1: idle valid got %0b expected 0", out_valid);
        end
        idle();
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R1: pending results got %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule